// File: doc/BRIEF.md
# Symmetric Toeplitz Flow Hash Unit

This unit computes a receive-side-scaling hash over the connection tuple of a packet and turns it into a receive queue number. The caller presents the IPv4 source and destination addresses, the two transport ports and the protocol number, then pulses `start`. The unit walks the 104-bit tuple one bit per clock. Each set bit folds a 32-bit slice of a sliding secret key into an accumulator. When the last bit has been handled, the unit raises `done` for one cycle. It then presents the 32-bit hash and the queue number. The queue number is read from a 128-entry indirection table, indexed by the low seven hash bits.

After reset, the key is the 16-bit word 0x6d5a repeated across all 320 bits. The key therefore repeats every 16 bits. Swapping the two addresses, and also the two ports, moves each field by a multiple of 16 bit positions. So both directions of one connection hash to the same value and land in the same queue. Both the key and the table can be rewritten while the unit is idle, to spread flows in other ways.

The controller has three states:
- `ST_IDLE` waits for `start`. `ST_IDLE -> ST_SHIFT` is taken when `start` is seen.
- `ST_SHIFT` consumes one tuple bit per cycle. `ST_SHIFT -> ST_REPORT` is taken on the final bit.
- `ST_REPORT` strobes `done`. `ST_REPORT -> ST_IDLE` follows unconditionally.

Top module: `flow_hash_unit`

## Requirements
- R1: After reset, `busy` and `done` are 0, `hash_out` is 0 and `queue_out` is 0.
- R2: The hash starts at zero. For each tuple bit, most significant first, the hash is XORed with the leftmost 32 bits of the current key window when that bit is 1. The window then shifts left by one position whether the bit was 0 or 1.
- R3: The 104-bit tuple is laid out as follows, and bit 103 is processed first:
  - `src_addr` in bits 103:72
  - `dst_addr` in bits 71:40
  - `src_port` in bits 39:24
  - `dst_port` in bits 23:8
  - `proto` in bits 7:0
- R4: `start` is accepted only while `busy` is 0. A `start` pulse while busy changes neither the result in progress nor the number of `done` strobes.
- R5: The pulse timing is fixed:
  - `busy` rises in the cycle after an accepted `start`.
  - `done` is high for exactly one cycle, the 105th cycle after the `start` sample edge.
  - `busy` stays high up to and including that cycle.
- R6: `hash_out` changes only in a cycle where `done` is high. Between strobes it holds the last result.
- R7: With the reset key, swapping `src_addr` with `dst_addr` and `src_port` with `dst_port` gives an identical hash and queue.
- R8: The key is rewritten through its write port:
  - A write with `key_wr_en` and index w (0 to 9) replaces 32-bit key word w.
  - Word 0 is the leftmost 32 bits, used for the first tuple bit.
  - The new word takes effect from the next computation.
  - Indices above 9 are dropped.
- R9: `queue_out` is the table entry at `hash_out[6:0]`. After reset, entry i holds i mod 16, so `queue_out` equals `hash_out[3:0]`. A write with `tbl_wr_en` replaces entry `tbl_wr_idx` with `tbl_wr_data`.
- R10: Key and table writes made while `busy` is 1 are dropped. They affect neither the current result nor later ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin hashing the presented tuple |
| src_addr | input | 32 | Source IPv4 address |
| dst_addr | input | 32 | Destination IPv4 address |
| src_port | input | 16 | Source transport port |
| dst_port | input | 16 | Destination transport port |
| proto | input | 8 | Protocol number |
| key_wr_en | input | 1 | Key word write strobe |
| key_wr_idx | input | 4 | Key word index, 0 is leftmost |
| key_wr_data | input | 32 | Key word value |
| tbl_wr_en | input | 1 | Indirection entry write strobe |
| tbl_wr_idx | input | 7 | Indirection entry index |
| tbl_wr_data | input | 4 | Queue number for that entry |
| busy | output | 1 | A tuple is being hashed or reported |
| done | output | 1 | One-cycle result strobe |
| hash_out | output | 32 | Last computed hash |
| queue_out | output | 4 | Queue selected by the last hash |

## Verification
The assertions assume that `start` is a level sampled on the clock. They also assume that nothing outside the unit ever forces `busy` low mid-run, so the cycle count they keep from the rise of `busy` is exact.

The stimulus raises `start` only one cycle after it has sampled `busy` low. It deliberately injects extra `start` pulses and write strobes only in the middle of a run, well away from the first and last busy cycles. The latency assertion therefore always sees a clean run. The dropped-write checks observe their effect purely through later hashes and queue numbers.

// File: rtl/flow_hash_pkg.sv
`timescale 1ns/1ps
package flow_hash_pkg;

    localparam int HASH_W   = 32;
    localparam int ADDR_W   = 32;
    localparam int PORT_W   = 16;
    localparam int PROTO_W  = 8;
    localparam int TUPLE_W  = 2 * ADDR_W + 2 * PORT_W + PROTO_W;
    localparam int PAT_W    = 16;
    localparam logic [PAT_W-1:0] SYM_PATTERN = 16'h6d5a;

    typedef struct packed {
        logic [ADDR_W-1:0]  src_addr;
        logic [ADDR_W-1:0]  dst_addr;
        logic [PORT_W-1:0]  src_port;
        logic [PORT_W-1:0]  dst_port;
        logic [PROTO_W-1:0] proto;
    } flow_tuple_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_REPORT = 2'd2
    } fh_state_e;

endpackage

// File: rtl/fh_key_store.sv
`timescale 1ns/1ps
module fh_key_store #(
    parameter int KEY_W  = 320,
    parameter int WORD_W = 32,
    parameter int PAT_W  = 16,
    parameter logic [PAT_W-1:0] PATTERN = 16'h6d5a
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic [$clog2(KEY_W/WORD_W)-1:0]        wr_idx,
    input  logic [WORD_W-1:0]                      wr_data,
    output logic [KEY_W-1:0]                       key
);
    localparam int NWORDS = KEY_W / WORD_W;
    localparam int AW     = $clog2(NWORDS);
    localparam int NCHUNK = KEY_W / PAT_W;

    logic [KEY_W-1:0] default_key;
    logic [KEY_W-1:0] key_q;

    // Repeating pattern fills the whole key (symmetric default)
    for (genvar c = 0; c < NCHUNK; c++) begin : g_pat
        assign default_key[c*PAT_W +: PAT_W] = PATTERN;
    end
    if (NCHUNK * PAT_W < KEY_W) begin : g_pad
        assign default_key[KEY_W-1:NCHUNK*PAT_W] = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q <= default_key;
        end else if (wr_en && (wr_idx < AW'(NWORDS))) begin
            // word 0 is the leftmost slice
            key_q[KEY_W - 1 - int'(wr_idx) * WORD_W -: WORD_W] <= wr_data;
        end
    end

    assign key = key_q;
endmodule

// File: rtl/fh_indir_table.sv
`timescale 1ns/1ps
module fh_indir_table #(
    parameter int DEPTH      = 128,
    parameter int NUM_QUEUES = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [$clog2(DEPTH)-1:0]      wr_idx,
    input  logic [$clog2(NUM_QUEUES)-1:0] wr_data,
    input  logic [$clog2(DEPTH)-1:0]      rd_idx,
    output logic [$clog2(NUM_QUEUES)-1:0] rd_data
);
    localparam int QW = $clog2(NUM_QUEUES);

    logic [QW-1:0] entry_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                entry_q[i] <= QW'(i % NUM_QUEUES);
            end
        end else if (wr_en) begin
            entry_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = entry_q[rd_idx];
endmodule

// File: rtl/fh_engine.sv
`timescale 1ns/1ps
module fh_engine
    import flow_hash_pkg::*;
#(
    parameter int KEY_W = 320,
    parameter int IN_W  = TUPLE_W,
    parameter int OUT_W = HASH_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IN_W-1:0]  tuple,
    input  logic [KEY_W-1:0] key,
    output logic             busy,
    output logic             done,
    output logic [OUT_W-1:0] hash
);
    // Only the key bits reachable by the last tuple bit are kept
    localparam int WIN_W = IN_W - 1 + OUT_W;
    localparam int CNT_W = $clog2(IN_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(IN_W - 1);

    fh_state_e        state_q, state_d;
    logic [IN_W-1:0]  bits_q;
    logic [WIN_W-1:0] win_q;
    logic [WIN_W-1:0] key_head;
    logic [OUT_W-1:0] acc_q;
    logic [OUT_W-1:0] acc_next;
    logic [OUT_W-1:0] result_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last_bit;

    if (KEY_W >= WIN_W) begin : g_key_trim
        assign key_head = key[KEY_W-1 -: WIN_W];
    end else begin : g_key_pad
        assign key_head = {key, {(WIN_W - KEY_W){1'b0}}};
    end

    assign last_bit = (cnt_q == LAST);
    assign acc_next = bits_q[IN_W-1] ? (acc_q ^ win_q[WIN_W-1 -: OUT_W]) : acc_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start)    state_d = ST_SHIFT;
            ST_SHIFT:  if (last_bit) state_d = ST_REPORT;
            ST_REPORT:               state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // bit-serial datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q   <= '0;
            win_q    <= '0;
            acc_q    <= '0;
            cnt_q    <= '0;
            result_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        bits_q <= tuple;
                        win_q  <= key_head;
                        acc_q  <= '0;
                        cnt_q  <= '0;
                    end
                end
                ST_SHIFT: begin
                    acc_q  <= acc_next;
                    win_q  <= win_q << 1;
                    bits_q <= bits_q << 1;
                    cnt_q  <= cnt_q + 1'b1;
                    if (last_bit) result_q <= acc_next;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_SHIFT:  busy = 1'b1;
            ST_REPORT: begin busy = 1'b1; done = 1'b1; end
            default:   ;
        endcase
    end

    assign hash = result_q;
endmodule

// File: rtl/flow_hash_unit.sv
`timescale 1ns/1ps
module flow_hash_unit
    import flow_hash_pkg::*;
#(
    parameter int KEY_W      = 320,
    parameter int KEY_WORD_W = 32,
    parameter int IND_DEPTH  = 128,
    parameter int NUM_QUEUES = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  start,
    input  logic [31:0]                           src_addr,
    input  logic [31:0]                           dst_addr,
    input  logic [15:0]                           src_port,
    input  logic [15:0]                           dst_port,
    input  logic [7:0]                            proto,
    input  logic                                  key_wr_en,
    input  logic [$clog2(KEY_W/KEY_WORD_W)-1:0]   key_wr_idx,
    input  logic [KEY_WORD_W-1:0]                 key_wr_data,
    input  logic                                  tbl_wr_en,
    input  logic [$clog2(IND_DEPTH)-1:0]          tbl_wr_idx,
    input  logic [$clog2(NUM_QUEUES)-1:0]         tbl_wr_data,
    output logic                                  busy,
    output logic                                  done,
    output logic [31:0]                           hash_out,
    output logic [$clog2(NUM_QUEUES)-1:0]         queue_out
);
    localparam int IND_AW = $clog2(IND_DEPTH);

    flow_tuple_t      tup;
    logic [KEY_W-1:0] key;
    logic             eng_busy;

    assign tup = '{src_addr: src_addr, dst_addr: dst_addr,
                   src_port: src_port, dst_port: dst_port, proto: proto};

    fh_key_store #(
        .KEY_W   (KEY_W),
        .WORD_W  (KEY_WORD_W),
        .PAT_W   (PAT_W),
        .PATTERN (SYM_PATTERN)
    ) u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (key_wr_en && !eng_busy),
        .wr_idx  (key_wr_idx),
        .wr_data (key_wr_data),
        .key     (key)
    );

    fh_engine #(
        .KEY_W (KEY_W),
        .IN_W  (TUPLE_W),
        .OUT_W (HASH_W)
    ) u_eng (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .tuple (tup),
        .key   (key),
        .busy  (eng_busy),
        .done  (done),
        .hash  (hash_out)
    );

    fh_indir_table #(
        .DEPTH      (IND_DEPTH),
        .NUM_QUEUES (NUM_QUEUES)
    ) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_wr_en && !eng_busy),
        .wr_idx  (tbl_wr_idx),
        .wr_data (tbl_wr_data),
        .rd_idx  (hash_out[IND_AW-1:0]),
        .rd_data (queue_out)
    );

    assign busy = eng_busy;
endmodule

// File: rtl/flow_hash_unit_chk.sv
`timescale 1ns/1ps
module flow_hash_unit_chk #(
    parameter int LAT    = 104,
    parameter int HASH_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [HASH_W-1:0] hash_out
);
    localparam int CW = $clog2(LAT + 2);

    logic [CW-1:0] busy_cyc;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_cyc <= '0;
        else                 busy_cyc <= busy_cyc + 1'b1;
    end

    a_r4_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r4_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    a_r5_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_cyc == CW'(LAT)));

    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r5_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r6_hash_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(hash_out));
endmodule

bind flow_hash_unit flow_hash_unit_chk #(
    .LAT    (flow_hash_pkg::TUPLE_W),
    .HASH_W (32)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .hash_out (hash_out)
);

// File: tb/flow_hash_unit_test.sv
`timescale 1ns/1ps
module flow_hash_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] src_addr = '0, dst_addr = '0;
    logic [15:0] src_port = '0, dst_port = '0;
    logic [7:0]  proto = '0;
    logic        key_wr_en = 1'b0;
    logic [3:0]  key_wr_idx = '0;
    logic [31:0] key_wr_data = '0;
    logic        tbl_wr_en = 1'b0;
    logic [6:0]  tbl_wr_idx = '0;
    logic [3:0]  tbl_wr_data = '0;
    logic        busy, done;
    logic [31:0] hash_out;
    logic [3:0]  queue_out;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [319:0] m_key;
    logic [3:0]   m_tbl [128];
    logic [31:0]  exp_h [$];
    logic [3:0]   exp_q [$];
    string        exp_tag [$];
    logic [31:0]  last_hash = '0;

    always #2 clk = ~clk;

    flow_hash_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_addr(src_addr), .dst_addr(dst_addr),
        .src_port(src_port), .dst_port(dst_port), .proto(proto),
        .key_wr_en(key_wr_en), .key_wr_idx(key_wr_idx), .key_wr_data(key_wr_data),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_data(tbl_wr_data),
        .busy(busy), .done(done), .hash_out(hash_out), .queue_out(queue_out)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // reference: bit-serial key-window fold, msb first
    function automatic logic [31:0] ref_hash(input logic [319:0] k, input logic [103:0] t);
        logic [31:0]  h = '0;
        logic [319:0] w = k;
        for (int i = 103; i >= 0; i--) begin
            if (t[i]) h = h ^ w[319:288];
            w = w << 1;
        end
        return h;
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_h.size() == 0) begin
                check(1'b0, "R4 unexpected done strobe", 64'(hash_out), 64'h0);
            end else begin
                logic [31:0] eh;
                logic [3:0]  eq;
                string       tg;
                eh = exp_h.pop_front();
                eq = exp_q.pop_front();
                tg = exp_tag.pop_front();
                check(hash_out == eh, {tg, " hash"}, 64'(hash_out), 64'(eh));
                check(queue_out == eq, {tg, " queue R9"}, 64'(queue_out), 64'(eq));
            end
            last_hash = hash_out;
        end
    end

    task automatic key_write(input logic [3:0] idx, input logic [31:0] val);
        @(posedge clk); #1;
        key_wr_en = 1'b1; key_wr_idx = idx; key_wr_data = val;
        @(posedge clk); #1;
        key_wr_en = 1'b0;
        if (idx < 10) m_key[319 - int'(idx)*32 -: 32] = val;
    endtask

    task automatic tbl_write(input logic [6:0] idx, input logic [3:0] val);
        @(posedge clk); #1;
        tbl_wr_en = 1'b1; tbl_wr_idx = idx; tbl_wr_data = val;
        @(posedge clk); #1;
        tbl_wr_en = 1'b0;
        m_tbl[idx] = val;
    endtask

    // disturb: inject start, key write and table write in mid-run
    task automatic run_flow(input logic [31:0] sa, input logic [31:0] da,
                            input logic [15:0] sp, input logic [15:0] dp,
                            input logic [7:0] pr, input string tag, input bit disturb);
        logic [103:0] t;
        logic [31:0]  h;
        int n;
        t = {sa, da, sp, dp, pr};
        h = ref_hash(m_key, t);
        exp_h.push_back(h);
        exp_q.push_back(m_tbl[h[6:0]]);
        exp_tag.push_back(tag);
        @(negedge clk);
        while (busy) @(negedge clk);
        @(posedge clk); #1;
        start = 1'b1; src_addr = sa; dst_addr = da; src_port = sp; dst_port = dp; proto = pr;
        @(posedge clk); #1;
        start = 1'b0;
        n = 0;
        if (disturb) begin
            repeat (10) begin @(negedge clk); n++; end
            check(busy == 1'b1, "R5 busy during run", 64'(busy), 64'h1);
            @(posedge clk); #1;
            start = 1'b1; src_addr = ~sa; dst_addr = 32'h1234_5678;
            key_wr_en = 1'b1; key_wr_idx = 4'd0; key_wr_data = ~m_key[319:288];
            tbl_wr_en = 1'b1; tbl_wr_idx = h[6:0]; tbl_wr_data = ~m_tbl[h[6:0]];
            @(posedge clk); #1;
            start = 1'b0; key_wr_en = 1'b0; tbl_wr_en = 1'b0;
            n += 1;
        end
        do begin
            @(negedge clk);
            n++;
        end while (!done && n < 300);
        check(n == 105, {tag, " R5 latency"}, 64'(n), 64'd105);
        @(negedge clk);
        check(done == 1'b0, {tag, " R5 single done"}, 64'(done), 64'h0);
        check(busy == 1'b0, {tag, " R5 busy drops"}, 64'(busy), 64'h0);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] fwd_h;
        logic [3:0]  fwd_q;
        for (int c = 0; c < 20; c++) m_key[c*16 +: 16] = 16'h6d5a;
        for (int i = 0; i < 128; i++) m_tbl[i] = 4'(i % 16);

        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy == 0, "R1 busy", 64'(busy), 0);
        check(done == 0, "R1 done", 64'(done), 0);
        check(hash_out == 0, "R1 hash", 64'(hash_out), 0);
        check(queue_out == 0, "R1 queue", 64'(queue_out), 0);

        // R2/R3 patterns
        run_flow(32'h0, 32'h0, 16'h0, 16'h0, 8'h0, "R2 zeros", 0);
        check(hash_out == 0, "R2 zero tuple", 64'(hash_out), 0);
        run_flow(32'h8000_0000, 32'h0, 16'h0, 16'h0, 8'h0, "R3 first bit", 0);
        check(hash_out == m_key[319:288], "R3 msb first", 64'(hash_out), 64'(m_key[319:288]));
        run_flow(32'h0, 32'h0, 16'h0, 16'h0, 8'h01, "R3 last bit", 0);
        check(hash_out == m_key[216:185], "R3 proto lsb", 64'(hash_out), 64'(m_key[216:185]));
        run_flow('1, '1, '1, '1, '1, "R2 ones", 0);
        run_flow(32'hc0a8_0101, 32'h0a00_0002, 16'd443, 16'd51000, 8'd6, "R2 tcp flow", 0);
        check(queue_out == hash_out[3:0], "R9 default table", 64'(queue_out), 64'(hash_out[3:0]));

        // R6 hold
        repeat (20) @(negedge clk);
        check(hash_out == last_hash, "R6 hash hold", 64'(hash_out), 64'(last_hash));

        // R7 symmetry
        run_flow(32'h4261_0a17, 32'h0d0e_ad01, 16'd1234, 16'd80, 8'd17, "R7 fwd", 0);
        fwd_h = hash_out; fwd_q = queue_out;
        run_flow(32'h0d0e_ad01, 32'h4261_0a17, 16'd80, 16'd1234, 8'd17, "R7 rev", 0);
        check(hash_out == fwd_h, "R7 swapped hash", 64'(hash_out), 64'(fwd_h));
        check(queue_out == fwd_q, "R7 swapped queue", 64'(queue_out), 64'(fwd_q));

        // R4 / R10 disturbance mid-run
        run_flow(32'h0102_0304, 32'h0506_0708, 16'd9, 16'd10, 8'd6, "R4 R10 busy writes", 1);
        run_flow(32'h8000_0000, 32'h0, 16'h0, 16'h0, 8'h0, "R10 key kept", 0);
        check(hash_out == 32'h6d5a_6d5a, "R10 key word0 kept", 64'(hash_out), 64'h6d5a6d5a);
        repeat (130) @(negedge clk);
        check(exp_h.size() == 0, "R4 no extra result", 64'(exp_h.size()), 0);

        // R8 key rewrite
        for (int w = 0; w < 10; w++) key_write(4'(w), 32'h9e37_79b9 * (w + 1) ^ 32'h5bd1_e995);
        key_write(4'd12, 32'hffff_ffff);
        run_flow(32'h8000_0000, 32'h0, 16'h0, 16'h0, 8'h0, "R8 word0", 0);
        check(hash_out == m_key[319:288], "R8 word0 direct", 64'(hash_out), 64'(m_key[319:288]));
        run_flow(32'hdead_beef, 32'h0bad_f00d, 16'd53, 16'd4000, 8'd17, "R8 new key", 0);
        run_flow(32'h0a0a_0a0a, 32'h1414_1414, 16'd22, 16'd60000, 8'd6, "R8 new key b", 0);

        // R9 table rewrite
        for (int i = 0; i < 128; i++) tbl_write(7'(i), 4'((i * 7 + 3) % 16));
        run_flow(32'hac10_0001, 32'hac10_00fe, 16'd5353, 16'd5353, 8'd17, "R9 new table", 0);
        run_flow(32'h7f00_0001, 32'h7f00_0001, 16'd1, 16'd2, 8'd1, "R9 new table b", 0);

        repeat (5) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule